// File: doc/BRIEF.md
# Byte-Loaded Double-Buffered Converter Code Register

This block is the digital front end of a 12-bit digital-to-analog converter. A host sees it as a memory-mapped peripheral on an 8-bit data bus. The code to convert is kept in two stages. A staging word is filled by two byte writes, and an output word drives the converter. Because the two stages are separate, the host can stage a new code without disturbing the converter output, and then commit it at a moment of its choosing.

The staging word is right-justified. The low byte supplies bits 7..0, and the lower nibble of the high byte supplies bits 11..8. The block has two commit styles, chosen by a mode input. In split mode a write to a dedicated commit address copies the staging word to the output. In chained mode the high-byte write stores its nibble and commits the full word in the same operation.

An active-low update strobe also commits the staging word. It is independent of the bus and may be wired to many instances so that all of their outputs change in the same clock cycle.

Top module: `bdac_front`

## Requirements
- R1: A synchronous active-high reset clears both the staging word and the output word to 0. A commit issued right after reset drives 0 on the output.
- R2: A write to address 0 loads bus_wdata[7:0] into staging bits 7..0. A write to address 1 loads bus_wdata[3:0] into staging bits 11..8, and bus_wdata[7:4] is ignored.
- R3: In split mode (auto_mode=0) the staging bytes may be written in either order. Neither byte write changes code_out.
- R4: In split mode a write to address 2 copies the whole staging word to code_out, which shows the new value after that clock edge. The data on the bus is ignored.
- R5: In chained mode (auto_mode=1) a write to address 1 stores its nibble and commits the resulting 12-bit word to code_out at the same clock edge.
- R6: In chained mode a write to address 2 has no effect.
- R7: A falling edge of upd_n passes through a two-flop synchronizer and commits exactly once. code_out changes at the third rising edge at which upd_n is sampled low. Holding upd_n low does not cause a second commit.
- R8: If a strobe commit and a byte write fall in the same cycle, one commit takes place, and it uses the staging word with that byte already applied.
- R9: A write takes place only in a cycle where bus_sel_n and bus_wr_n are both low. A write to address 3 has no effect.
- R10: Several instances that share upd_n, each preloaded with a different staging word, all update code_out in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel_n | input | 1 | Block select, active low |
| bus_wr_n | input | 1 | Write enable, active low |
| bus_addr | input | 2 | Register address: 0 low byte, 1 high byte, 2 commit, 3 unused |
| bus_wdata | input | 8 | Write data |
| upd_n | input | 1 | Asynchronous update strobe, active low, may be shared between instances |
| auto_mode | input | 1 | 0 split commit, 1 chained commit on high-byte write |
| code_out | output | 12 | Code driven to the converter |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, a 12-bit code and a two-stage strobe synchronizer. With these values the 4-bit high field, and the ignored upper nibble of the high-byte write, appear at the ports. The strobe latency is exactly three edges, so the bench can check the cycle before and the cycle of the update. Two instances share one strobe, so a broadcast commit can be checked, and so can a strobe commit that coincides with a byte write.

// File: rtl/bdac_pkg.sv
package bdac_pkg;

    // Default geometry of the block
    localparam int unsigned BUS_W_DEF   = 8;
    localparam int unsigned CODE_W_DEF  = 12;
    localparam int unsigned SYNC_N_DEF  = 2;
    localparam int unsigned ADDR_W      = 2;

    // Register map; the high-byte slot doubles as commit in chained mode
    typedef enum logic [ADDR_W-1:0] {
        REG_LO    = 2'd0,
        REG_HI    = 2'd1,
        REG_XFER  = 2'd2,
        REG_SPARE = 2'd3
    } reg_sel_e;

    // Commit style
    typedef enum logic {
        MODE_SPLIT   = 1'b0,
        MODE_CHAINED = 1'b1
    } commit_mode_e;

    // Actions decoded from one bus cycle
    typedef struct packed {
        logic load_lo;
        logic load_hi;
        logic commit;
    } bus_act_t;

    // Decode a bus cycle into latch actions
    function automatic bus_act_t decode_cycle(
        input logic         wr_active,
        input reg_sel_e     sel,
        input commit_mode_e mode
    );
        bus_act_t a;
        a.load_lo = wr_active && (sel == REG_LO);
        a.load_hi = wr_active && (sel == REG_HI);
        a.commit  = wr_active &&
                    (((sel == REG_XFER) && (mode == MODE_SPLIT)) ||
                     ((sel == REG_HI)   && (mode == MODE_CHAINED)));
        return a;
    endfunction

endpackage

// File: rtl/bdac_bus_decode.sv
module bdac_bus_decode
    import bdac_pkg::*;
(
    input  logic                bus_sel_n,
    input  logic                bus_wr_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                auto_mode,
    output bus_act_t            act
);

    logic         wr_active;
    reg_sel_e     sel;
    commit_mode_e mode;

    always_comb begin
        wr_active = !bus_sel_n && !bus_wr_n;
        sel       = reg_sel_e'(bus_addr);
        mode      = commit_mode_e'(auto_mode);
        act       = decode_cycle(wr_active, sel, mode);
    end

endmodule

// File: rtl/bdac_edge_sync.sv
module bdac_edge_sync #(
    parameter int unsigned STAGES = bdac_pkg::SYNC_N_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic fire
);

    // Idle level of the strobe is high; reset loads the idle level
    logic [STAGES-1:0] stage_q;
    logic              last_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[gi] <= 1'b1;
                    else     stage_q[gi] <= strobe_n;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[gi] <= 1'b1;
                    else     stage_q[gi] <= stage_q[gi-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b1;
        else     last_q <= stage_q[STAGES-1];
    end

    // One-cycle pulse on a high-to-low transition of the synchronized strobe
    assign fire = last_q && !stage_q[STAGES-1];

endmodule

// File: rtl/bdac_latch_pair.sv
module bdac_latch_pair
    import bdac_pkg::*;
#(
    parameter int unsigned BUS_W  = BUS_W_DEF,
    parameter int unsigned CODE_W = CODE_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_act_t          act,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              fire,
    output logic [CODE_W-1:0] stage_word,
    output logic [CODE_W-1:0] out_word
);

    localparam int unsigned HI_W = CODE_W - BUS_W;

    logic [CODE_W-1:0] stage_q;
    logic [CODE_W-1:0] out_q;
    logic [CODE_W-1:0] stage_nx;
    logic              take;
    logic              unused_hi_bits;

    assign unused_hi_bits = ^wdata[BUS_W-1:HI_W];

    // Staging value with this cycle's byte write applied
    always_comb begin
        stage_nx = stage_q;
        if (act.load_lo) stage_nx[BUS_W-1:0]      = wdata;
        if (act.load_hi) stage_nx[CODE_W-1:BUS_W] = wdata[HI_W-1:0];
        take = act.commit || fire;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            out_q   <= '0;
        end else begin
            stage_q <= stage_nx;
            if (take) out_q <= stage_nx;
        end
    end

    assign stage_word = stage_q;
    assign out_word   = out_q;

endmodule

// File: rtl/bdac_front.sv
module bdac_front
    import bdac_pkg::*;
#(
    parameter int unsigned BUS_W   = BUS_W_DEF,
    parameter int unsigned CODE_W  = CODE_W_DEF,
    parameter int unsigned SYNC_N  = SYNC_N_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel_n,
    input  logic              bus_wr_n,
    input  logic [1:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              upd_n,
    input  logic              auto_mode,
    output logic [CODE_W-1:0] code_out
);

    bus_act_t          act;
    logic              upd_fire;
    logic [CODE_W-1:0] in_word;

    bdac_bus_decode u_dec (
        .bus_sel_n (bus_sel_n),
        .bus_wr_n  (bus_wr_n),
        .bus_addr  (bus_addr),
        .auto_mode (auto_mode),
        .act       (act)
    );

    bdac_edge_sync #(.STAGES(SYNC_N)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .strobe_n (upd_n),
        .fire     (upd_fire)
    );

    bdac_latch_pair #(.BUS_W(BUS_W), .CODE_W(CODE_W)) u_latch (
        .clk        (clk),
        .rst        (rst),
        .act        (act),
        .wdata      (bus_wdata),
        .fire       (upd_fire),
        .stage_word (in_word),
        .out_word   (code_out)
    );

endmodule

// File: rtl/bdac_front_chk.sv
module bdac_front_chk #(
    parameter int unsigned BUS_W  = 8,
    parameter int unsigned CODE_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel_n,
    input logic              bus_wr_n,
    input logic [1:0]        bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic              auto_mode,
    input logic [CODE_W-1:0] code_out,
    input logic [CODE_W-1:0] in_word,
    input logic              upd_fire
);

    localparam int unsigned HI_W = CODE_W - BUS_W;

    logic wr_on;
    logic bus_commit;
    assign wr_on      = !bus_sel_n && !bus_wr_n;
    assign bus_commit = wr_on && (((bus_addr == 2'd2) && !auto_mode) ||
                                  ((bus_addr == 2'd1) &&  auto_mode));

    AST_LO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_on && bus_addr == 2'd0) |=> (in_word[BUS_W-1:0] == $past(bus_wdata))); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!bus_commit && !upd_fire) |=> $stable(code_out)); // R3

    AST_SPLIT_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (wr_on && !auto_mode && bus_addr == 2'd2 && !upd_fire)
        |=> (code_out == $past(in_word))); // R4

    AST_CHAIN_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (wr_on && auto_mode && bus_addr == 2'd1)
        |=> (code_out[CODE_W-1:BUS_W] == $past(bus_wdata[HI_W-1:0]) &&
             code_out[BUS_W-1:0] == $past(in_word[BUS_W-1:0]))); // R5

    AST_CHAIN_XFER_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_on && auto_mode && bus_addr == 2'd2 && !upd_fire)
        |=> $stable(code_out)); // R6

    AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        upd_fire |=> !upd_fire); // R7

    AST_MERGED_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (upd_fire && wr_on && bus_addr == 2'd0)
        |=> (code_out[BUS_W-1:0] == $past(bus_wdata))); // R8

endmodule

bind bdac_front bdac_front_chk #(.BUS_W(BUS_W), .CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel_n (bus_sel_n),
    .bus_wr_n  (bus_wr_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .auto_mode (auto_mode),
    .code_out  (code_out),
    .in_word   (in_word),
    .upd_fire  (upd_fire)
);

// File: tb/bdac_front_tb.sv
`timescale 1ns/1ps
module bdac_front_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        sel_a_n, sel_b_n, wr_n;
    logic [1:0]  addr;
    logic [7:0]  wdata;
    logic        upd_n;
    logic        auto_mode;
    logic [11:0] code_a, code_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bdac_front u_dut (
        .clk(clk), .rst(rst), .bus_sel_n(sel_a_n), .bus_wr_n(wr_n),
        .bus_addr(addr), .bus_wdata(wdata), .upd_n(upd_n),
        .auto_mode(auto_mode), .code_out(code_a)
    );

    bdac_front u_dut2 (
        .clk(clk), .rst(rst), .bus_sel_n(sel_b_n), .bus_wr_n(wr_n),
        .bus_addr(addr), .bus_wdata(wdata), .upd_n(upd_n),
        .auto_mode(auto_mode), .code_out(code_b)
    );

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One-cycle bus write; which = 1 for instance A, 2 for B, 3 for both.
    // Called at a negative edge, returns at the next negative edge.
    task automatic bus_write(input int which, input logic [1:0] a, input logic [7:0] d);
        sel_a_n = !(which == 1 || which == 3);
        sel_b_n = !(which == 2 || which == 3);
        wr_n = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        sel_a_n = 1'b1; sel_b_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic t_reset;
        chk("R1 reset A", code_a, 12'h000);
        chk("R1 reset B", code_b, 12'h000);
        bus_write(3, 2'd2, 8'hFF);
        chk("R1 commit after reset", code_a, 12'h000);
    endtask

    task automatic t_split_lo_first;
        bus_write(1, 2'd0, 8'hA5);
        chk("R3 lo write holds out", code_a, 12'h000);
        bus_write(1, 2'd1, 8'h3C);
        chk("R3 hi write holds out", code_a, 12'h000);
        bus_write(1, 2'd2, 8'h00);
        chk("R4 R2 commit lo-first", code_a, 12'hCA5);
    endtask

    task automatic t_split_hi_first;
        bus_write(1, 2'd1, 8'h07);
        chk("R3 hi-first holds out", code_a, 12'hCA5);
        bus_write(1, 2'd0, 8'h1E);
        chk("R3 lo-second holds out", code_a, 12'hCA5);
        bus_write(1, 2'd2, 8'hFF);
        chk("R4 commit hi-first", code_a, 12'h71E);
    endtask

    task automatic t_gating;
        sel_a_n = 1'b1; wr_n = 1'b0; addr = 2'd0; wdata = 8'h55;
        @(negedge clk);
        wr_n = 1'b1;
        sel_a_n = 1'b0; addr = 2'd0; wdata = 8'h66;
        @(negedge clk);
        sel_a_n = 1'b1;
        bus_write(1, 2'd3, 8'h99);
        chk("R9 ignored cycles hold out", code_a, 12'h71E);
        bus_write(1, 2'd2, 8'h00);
        chk("R9 staging untouched", code_a, 12'h71E);
    endtask

    task automatic t_chained;
        auto_mode = 1'b1;
        @(negedge clk);
        bus_write(1, 2'd0, 8'h34);
        chk("R5 lo write holds out", code_a, 12'h71E);
        bus_write(1, 2'd1, 8'h59);
        chk("R5 hi write commits", code_a, 12'h934);
        bus_write(1, 2'd0, 8'h00);
        bus_write(1, 2'd2, 8'h00);
        chk("R6 commit addr ignored", code_a, 12'h934);
        auto_mode = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_broadcast;
        bus_write(1, 2'd0, 8'h23);
        bus_write(1, 2'd1, 8'h01);
        bus_write(2, 2'd1, 8'h0A);
        bus_write(2, 2'd0, 8'hBC);
        chk("R10 preload holds A", code_a, 12'h934);
        chk("R10 preload holds B", code_b, 12'h000);
        upd_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R7 no update before third edge", code_a, 12'h934);
        @(negedge clk);
        chk("R10 R7 A updated", code_a, 12'h123);
        chk("R10 B updated", code_b, 12'hABC);
        repeat (4) @(negedge clk);
        bus_write(1, 2'd0, 8'hFF);
        repeat (3) @(negedge clk);
        chk("R7 held strobe no repeat", code_a, 12'h123);
        upd_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_merge;
        upd_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        bus_write(1, 2'd0, 8'h66);
        chk("R8 merged commit A", code_a, 12'h166);
        chk("R8 B unaffected by A write", code_b, 12'hABC);
        upd_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; sel_a_n = 1'b1; sel_b_n = 1'b1; wr_n = 1'b1;
        addr = 2'd0; wdata = 8'h00; upd_n = 1'b1; auto_mode = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_split_lo_first();
        t_split_hi_first();
        t_gating();
        t_chained();
        t_broadcast();
        t_merge();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule